// File: doc/BRIEF.md
# Three-Wire Power Switch Serializer

This block carries socket power-control words from a host register interface to an external power switch. The switch listens on three lines: a serial clock, a data line and a latch strobe. A parallel control word and a one-cycle write strobe feed the block. It shifts the word out most significant bit first and then raises the latch strobe for one serial clock period. The switch captures data on rising serial clock edges and uses the word it has collected when the strobe appears.

The serial clock has two sources, selected by a mode input. When the block drives the clock, it divides the bus clock by an even parameter, 36 by default. At a 33 MHz bus clock this gives a serial clock under 1 MHz, well below the 2 MHz limit of the switch. When the clock comes from outside, the block synchronises the external clock and updates its outputs on the falling edges it detects. In both modes the data line and the latch strobe change only after a falling edge, so they are stable at every rising edge.

The block holds one write in reserve. A word written during a frame is sent straight after that frame ends. If more writes arrive during the same frame, the latest one replaces the word held. A busy flag and a one-cycle done pulse let the host pace its writes.

Top module: `pwrsw_serializer`

## Requirements
- R1: After reset: sclk_oe = 0, sclk_out = 1, sdata = 0, slatch = 0, busy = 0 and done = 0.
- R2: With clk_drive_en = 1, sclk_oe is 1 and sclk_out is periodic with a period of DIV bus clock cycles (36 by default): high for DIV/2 cycles, then low for DIV/2 cycles.
- R3: A frame carries the WORD_W-bit word (11 bits by default) MSB first, one bit per serial clock period. A receiver that captures sdata on each rising sclk edge holds the written word in its last WORD_W captures at the first rising edge where slatch is 1.
- R4: sdata and slatch change only after a falling serial clock edge. In internal-clock mode they never change while sclk_out stays high.
- R5: After the last bit, slatch is 1 for exactly one serial clock period (DIV bus cycles in internal mode), and sdata is 0 while slatch is 1.
- R6: With clk_drive_en = 0, sclk_oe is 0 and frames advance only on falling edges of the synchronised sclk_in. With no sclk_in edges, a written word stays pending: busy = 1 and slatch stays 0.
- R7: A write during a frame is held and sent after that frame. With several writes during one frame, only the last one is sent, so exactly two frames result.
- R8: busy is 1 from the cycle after ctl_wr until the final frame completes. done is a single-cycle pulse, one per frame, in the cycle after slatch falls.
- R9: With clk_drive_en = 0, sclk_out is held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_drive_en | input | 1 | 1: block generates the serial clock; 0: external clock on sclk_in |
| ctl_word | input | WORD_W | Power-control word to send |
| ctl_wr | input | 1 | One-cycle write strobe for ctl_word |
| sclk_in | input | 1 | External serial clock (external mode) |
| sclk_out | output | 1 | Generated serial clock |
| sclk_oe | output | 1 | Output enable for the serial clock pad |
| sdata | output | 1 | Serial data to the switch |
| slatch | output | 1 | Latch strobe marking a complete word |
| busy | output | 1 | A frame is in progress or a word is pending |
| done | output | 1 | One-cycle pulse when a frame completes |

## Verification
The assertions assume clk_drive_en changes only while busy is low, so a frame never runs on two clock sources. The stimulus changes the mode only after waiting for all outstanding frames to finish. In external mode the assertions assume each sclk_in half period is much longer than the synchroniser delay. The bench drives sclk_in with a 10-cycle half period, and it sends a burst of writes only while the previous frame is still shifting.

// File: rtl/pwrsw_pkg.sv
package pwrsw_pkg;
    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_SHIFT = 2'd1,
        SH_LATCH = 2'd2
    } sh_state_e;
endpackage

// File: rtl/pwrsw_clkdiv.sv
module pwrsw_clkdiv #(
    parameter int DIV = 36
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic sclk,
    output logic fall_tk
);
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sclk;
    } div_t;

    div_t d, q;
    logic rise_tk;

    // fall tick ends the high half, rise tick ends the low half
    assign fall_tk = en && (q.cnt == CW'(HALF - 1));
    assign rise_tk = en && (q.cnt == CW'(DIV - 1));

    always_comb begin
        d = q;
        if (!en) begin
            d.cnt  = '0;
            d.sclk = 1'b1;
        end else begin
            d.cnt = rise_tk ? '0 : q.cnt + CW'(1);
            if (fall_tk)
                d.sclk = 1'b0;
            else if (rise_tk)
                d.sclk = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt  <= '0;
            q.sclk <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sclk = q.sclk;
endmodule

// File: rtl/pwrsw_edgesync.sv
module pwrsw_edgesync #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic fall_tk
);
    typedef struct packed {
        logic [SYNC-1:0] sync;
        logic            prev;
    } es_t;

    es_t d, q;

    always_comb begin
        d      = q;
        d.sync = {q.sync[SYNC-2:0], async_in};
        d.prev = q.sync[SYNC-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync <= '1;
            q.prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign fall_tk = q.prev && !q.sync[SYNC-1];
endmodule

// File: rtl/pwrsw_shifter.sv
module pwrsw_shifter
    import pwrsw_pkg::*;
#(
    parameter int WORD_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              wr,
    input  logic [WORD_W-1:0] word,
    output logic              sdata,
    output logic              slatch,
    output logic              busy,
    output logic              done
);
    localparam int BW = (WORD_W > 2) ? $clog2(WORD_W) : 1;

    typedef struct packed {
        sh_state_e         st;
        logic [WORD_W-1:0] sh;
        logic [BW-1:0]     bitcnt;
        logic              pend_vld;
        logic [WORD_W-1:0] pend_word;
        logic              sdata;
        logic              slatch;
        logic              done;
    } shf_t;

    shf_t d, q;
    logic load;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        load   = 1'b0;
        if (adv) begin
            unique case (q.st)
                SH_IDLE: begin
                    load = q.pend_vld;
                end
                SH_SHIFT: begin
                    if (q.bitcnt == '0) begin
                        d.st     = SH_LATCH;
                        d.sdata  = 1'b0;
                        d.slatch = 1'b1;
                    end else begin
                        d.sh     = q.sh << 1;
                        d.sdata  = q.sh[WORD_W-2];
                        d.bitcnt = q.bitcnt - BW'(1);
                    end
                end
                SH_LATCH: begin
                    d.slatch = 1'b0;
                    d.done   = 1'b1;
                    load     = q.pend_vld;
                    if (!q.pend_vld)
                        d.st = SH_IDLE;
                end
                default: d.st = SH_IDLE;
            endcase
        end
        if (load) begin
            d.st     = SH_SHIFT;
            d.sh     = q.pend_word;
            d.sdata  = q.pend_word[WORD_W-1];
            d.bitcnt = BW'(WORD_W - 1);
        end
        // a write in the load cycle stays pending; a later write replaces
        d.pend_vld = (q.pend_vld && !load) || wr;
        if (wr)
            d.pend_word = word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st        <= SH_IDLE;
            q.sh        <= '0;
            q.bitcnt    <= '0;
            q.pend_vld  <= 1'b0;
            q.pend_word <= '0;
            q.sdata     <= 1'b0;
            q.slatch    <= 1'b0;
            q.done      <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sdata  = q.sdata;
    assign slatch = q.slatch;
    assign done   = q.done;
    assign busy   = (q.st != SH_IDLE) || q.pend_vld;
endmodule

// File: rtl/pwrsw_serializer.sv
module pwrsw_serializer #(
    parameter int WORD_W = 11,
    parameter int DIV    = 36,
    parameter int SYNC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_drive_en,
    input  logic [WORD_W-1:0] ctl_word,
    input  logic              ctl_wr,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              sclk_oe,
    output logic              sdata,
    output logic              slatch,
    output logic              busy,
    output logic              done
);
    logic div_fall;
    logic ext_fall;
    logic adv;

    pwrsw_clkdiv #(.DIV(DIV)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (clk_drive_en),
        .sclk    (sclk_out),
        .fall_tk (div_fall)
    );

    pwrsw_edgesync #(.SYNC(SYNC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sclk_in),
        .fall_tk  (ext_fall)
    );

    assign adv     = clk_drive_en ? div_fall : ext_fall;
    assign sclk_oe = clk_drive_en;

    pwrsw_shifter #(.WORD_W(WORD_W)) u_shf (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (adv),
        .wr     (ctl_wr),
        .word   (ctl_word),
        .sdata  (sdata),
        .slatch (slatch),
        .busy   (busy),
        .done   (done)
    );
endmodule

// File: rtl/pwrsw_serializer_chk.sv
module pwrsw_serializer_chk (
    input logic clk,
    input logic rst_n,
    input logic clk_drive_en,
    input logic ctl_wr,
    input logic sclk_out,
    input logic sdata,
    input logic slatch,
    input logic busy,
    input logic done
);
    // R4
    sdata_hold_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_drive_en && $past(clk_drive_en) && sclk_out && $past(sclk_out))
        |-> ($stable(sdata) && $stable(slatch)));

    // R5
    latch_data_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slatch |-> !sdata);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_after_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(slatch) && !slatch));

    // R8
    busy_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> busy);

    // R9
    ext_sclk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_drive_en && $past(!clk_drive_en)) |-> sclk_out);
endmodule

bind pwrsw_serializer pwrsw_serializer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clk_drive_en (clk_drive_en),
    .ctl_wr       (ctl_wr),
    .sclk_out     (sclk_out),
    .sdata        (sdata),
    .slatch       (slatch),
    .busy         (busy),
    .done         (done)
);

// File: tb/pwrsw_serializer_bench.sv
module pwrsw_serializer_bench;
    localparam int W   = 11;
    localparam int DIV = 36;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clk_drive_en = 1'b0;
    logic [W-1:0] ctl_word = '0;
    logic         ctl_wr = 1'b0;
    logic         sclk_in = 1'b1;
    logic         sclk_out, sclk_oe, sdata, slatch, busy, done;
    logic         ext_run = 1'b0;

    int errors = 0;
    int checks = 0;

    // receiver model and measurements
    logic [W-1:0] rx_sh = '0;
    logic [W-1:0] rx [0:63];
    int rx_n = 0;
    int done_cnt = 0;
    int cyc = 0;
    int last_rise = -1;
    int period = 0;
    int latch_run = 0;
    int latch_w = 0;
    int hi_chg = 0;
    logic p_rclk = 1'b1, p_sclk = 1'b1, p_sdata = 1'b0, p_slatch = 1'b0, p_drv = 1'b0;

    // bit 11: 1 = internal clock, 0 = external clock; bits 10:0 = word
    localparam logic [11:0] VEC [0:5] = '{
        12'h dA3, 12'h 7FF, 12'h c01, 12'h 400, 12'h aAA, 12'h 555
    };

    pwrsw_serializer #(.WORD_W(W), .DIV(DIV)) u_pwrsw_serializer (
        .clk(clk), .rst_n(rst_n), .clk_drive_en(clk_drive_en),
        .ctl_word(ctl_word), .ctl_wr(ctl_wr), .sclk_in(sclk_in),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdata(sdata),
        .slatch(slatch), .busy(busy), .done(done)
    );

    always #5 clk = ~clk;

    initial begin
        forever begin
            #100;
            if (ext_run) sclk_in = ~sclk_in;
        end
    end

    always @(negedge clk) begin
        logic rclk;
        cyc = cyc + 1;
        rclk = clk_drive_en ? sclk_out : sclk_in;
        if (rclk && !p_rclk) begin
            if (slatch) begin
                rx[rx_n[5:0]] = rx_sh;
                rx_n = rx_n + 1;
            end else begin
                rx_sh = {rx_sh[W-2:0], sdata};
            end
        end
        if (clk_drive_en && p_drv) begin
            if (sclk_out && !p_sclk) begin
                if (last_rise >= 0) period = cyc - last_rise;
                last_rise = cyc;
            end
            if (sclk_out && p_sclk && ((sdata != p_sdata) || (slatch != p_slatch)))
                hi_chg = hi_chg + 1;
        end else begin
            last_rise = -1;
        end
        if (slatch) latch_run = latch_run + 1;
        else if (p_slatch) latch_w = latch_run;
        if (!slatch) latch_run = 0;
        if (done) done_cnt = done_cnt + 1;
        p_rclk = rclk; p_sclk = sclk_out; p_sdata = sdata;
        p_slatch = slatch; p_drv = clk_drive_en;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [W-1:0] w);
        @(negedge clk);
        ctl_word = w;
        ctl_wr = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic wait_frames(input int n);
        int target = done_cnt + n;
        for (int t = 0; t < 8000 && done_cnt < target; t++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic set_mode(input logic drv);
        @(negedge clk);
        clk_drive_en = drv;
        ext_run = !drv;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk(sclk_oe == 1'b0, "R1 sclk_oe", sclk_oe, 0);
        chk(sclk_out == 1'b1, "R1 sclk_out", sclk_out, 1);
        chk({sdata, slatch, busy, done} == 4'b0, "R1 outputs",
            {sdata, slatch, busy, done}, 0);

        // table walk: R3 internal frames, R6 external frames, R8 one done each
        for (int i = 0; i < 6; i++) begin
            int d0, r0;
            set_mode(VEC[i][11]);
            d0 = done_cnt;
            r0 = rx_n;
            write_word(VEC[i][W-1:0]);
            chk(busy == 1'b1, "R8 busy after write", busy, 1);
            wait_frames(1);
            chk(rx_n == r0 + 1 && rx[r0[5:0]] == VEC[i][W-1:0],
                VEC[i][11] ? "R3 word received" : "R6 external word received",
                rx[r0[5:0]], VEC[i][W-1:0]);
            chk(done_cnt == d0 + 1, "R8 one done per frame", done_cnt - d0, 1);
            chk(busy == 1'b0, "R8 busy clear", busy, 0);
            if (VEC[i][11]) begin
                chk(sclk_oe == 1'b1, "R2 sclk_oe", sclk_oe, 1);
                chk(period == DIV, "R2 period", period, DIV);
                chk(latch_w == DIV, "R5 latch width", latch_w, DIV);
            end else begin
                chk(sclk_oe == 1'b0, "R6 sclk_oe", sclk_oe, 0);
                chk(sclk_out == 1'b1, "R9 sclk_out high", sclk_out, 1);
            end
        end

        // R7 queued write sent after current frame
        begin
            int r0;
            set_mode(1'b1);
            r0 = rx_n;
            write_word(11'h1C3);
            repeat (60) @(negedge clk);
            write_word(11'h63E);
            wait_frames(2);
            chk(rx_n == r0 + 2, "R7 two frames", rx_n - r0, 2);
            chk(rx[r0[5:0]] == 11'h1C3, "R7 first frame", rx[r0[5:0]], 11'h1C3);
            chk(rx[(r0 + 1) & 63] == 11'h63E, "R7 queued frame", rx[(r0 + 1) & 63], 11'h63E);
        end

        // R7 later write replaces held word
        begin
            int r0;
            r0 = rx_n;
            write_word(11'h0F0);
            repeat (60) @(negedge clk);
            write_word(11'h333);
            repeat (5) @(negedge clk);
            write_word(11'h4CC);
            wait_frames(2);
            repeat (200) @(negedge clk);
            chk(rx_n == r0 + 2, "R7 replace frame count", rx_n - r0, 2);
            chk(rx[(r0 + 1) & 63] == 11'h4CC, "R7 newest sent", rx[(r0 + 1) & 63], 11'h4CC);
        end

        // R4 no change while sclk_out high
        chk(hi_chg == 0, "R4 stable while high", hi_chg, 0);

        // R6 no external edges: word stays pending
        begin
            int r0;
            set_mode(1'b0);
            ext_run = 1'b0;
            repeat (20) @(negedge clk);
            r0 = rx_n;
            write_word(11'h2D7);
            repeat (300) @(negedge clk);
            chk(busy == 1'b1 && slatch == 1'b0 && rx_n == r0, "R6 stalled without edges",
                {busy, slatch}, 2'b10);
            chk(sclk_out == 1'b1, "R9 sclk_out high idle", sclk_out, 1);
            ext_run = 1'b1;
            wait_frames(1);
            chk(rx[r0[5:0]] == 11'h2D7, "R6 resumed word", rx[r0[5:0]], 11'h2D7);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule